// File: doc/BRIEF.md
# ADC Conversion Handshake Sequencer

This block drives one conversion on an external successive-approximation converter with 12 data bits plus a sign bit. The converter sits on a byte-wide bus with four active-low control lines: chip select, read, write and status select. After a single-cycle `start`, the sequencer works through a fixed order of steps. It first polls status until the converter is not busy. It then pulses the write line to begin a conversion and reads status once to confirm that conversion began. Next it waits a settle interval and polls status for data-ready. Finally it reads the result as a high byte followed by a low byte.

The result is taken only when one two-byte reading equals the reading before it. The first comparison is made against zero. Each failure mode has its own bounded retry count and returns its own 16-bit code. A one-cycle `done` pulse marks the moment `result` and `error` take their new values. The converter itself and whatever consumes the result are outside the block.

Top module: `adc_handshake_seq`

## Requirements
- R1: After a synchronous reset, all four strobes (`cs_n`, `rd_n`, `wr_n`, `ss_n`) are high, `busy` and `done` are 0, and `result` is 16'h0000. Whenever `busy` is 0, `cs_n` is high.
- R2: Every bus access drives `cs_n` low together with exactly one other strobe: `ss_n` for a status read, `wr_n` for the start pulse, and `rd_n` for a data read. Each low phase lasts exactly LOW_CYC cycles and is followed by at least HIGH_CYC high cycles. Bus data is sampled on the last low cycle.
- R3: Before starting, status is read up to BUSY_TRIES times until bit 6 (conversion in progress) is 0. If bit 6 is 1 on all of those reads, the run ends with result 16'hFFFF and error 1.
- R4: After the write pulse and START_DLY idle cycles, one status read must show bit 6 set. Otherwise the run ends with 16'hFFFE and error 1.
- R5: After a confirmed start, the block idles SETTLE_CYC cycles. It then polls status up to READY_TRIES times for bit 0 (data ready). If bit 0 never sets, the run ends with 16'hFFFD and error 1.
- R6: If the status read that shows data ready also has bit 2 set (low byte in the latch), exactly one dummy data read is issued before the first reading.
- R7: A reading is a high-byte read followed by a low-byte read. The value is {3'b000, high[4:0], low[7:0]}, so the top 3 bits of the high byte are discarded.
- R8: Readings repeat up to READ_TRIES times. The first reading that equals the previous one is returned with error 0; the "previous" value for the first reading is 0. If no such match occurs, the result is 16'h0000 with error 0.
- R9: `done` is high for exactly one cycle, in the first cycle that `busy` is 0. `result` and `error` change only in that cycle and hold until the next `done`. `error` is 1 only with one of the three codes.
- R10: `start` is ignored while `busy` is 1. When `busy` is 0, a `start` makes `busy` 1 in the next cycle.
- R11: With A = LOW_CYC + HIGH_CYC + 1 cycles per access, `done` rises 1 + T cycles after the cycle that carries `start`. T is the sum of A for every access plus START_DLY and SETTLE_CYC for the phases that were reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one conversion run (ignored while busy) |
| bus_in | input | 8 | Byte from the converter bus |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Start-conversion strobe, active low |
| ss_n | output | 1 | Status select strobe, active low |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 16 | Conversion value or error code |
| error | output | 1 | Result is one of the three error codes |

## Verification
Every access costs LOW_CYC + HIGH_CYC + 1 cycles, and the two fixed waits add START_DLY and SETTLE_CYC cycles. The cycle in which `done` must rise can therefore be written in closed form from the number of busy polls, ready polls, dummy reads and readings that a scenario forces. The bench counts clock edges from the cycle that carries `start` and samples at the falling edge. It compares that count with the closed form as well as checking the result and error flag. A converter model answers the strobes, and its scenario knobs are swept over a nested grid. A stray `start` is injected mid-run and the idle bus is checked a few cycles after each `done`.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [1:0] {
      ACC_STATUS,
      ACC_START,
      ACC_DATA
   } acc_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BUSYCHK,
      ST_START,
      ST_DELAY,
      ST_CONFIRM,
      ST_SETTLE,
      ST_POLL,
      ST_ALIGN,
      ST_RDHI,
      ST_RDLO
   } state_e;

   localparam logic [15:0] CODE_BUSY     = 16'hFFFF;
   localparam logic [15:0] CODE_NOSTART  = 16'hFFFE;
   localparam logic [15:0] CODE_STUCK    = 16'hFFFD;
   localparam logic [15:0] CODE_UNSTABLE = 16'h0000;

   localparam int BIT_INPROG = 6;
   localparam int BIT_LATCH  = 2;
   localparam int BIT_READY  = 0;

   localparam int NCNT       = 5;
   localparam int CNT_BUSY   = 0;
   localparam int CNT_DLY    = 1;
   localparam int CNT_SETTLE = 2;
   localparam int CNT_READY  = 3;
   localparam int CNT_READ   = 4;

endpackage

// File: rtl/adcseq_strobe.sv
module adcseq_strobe
   import adcseq_pkg::*;
#(
   parameter int unsigned LOW_CYC  = 4,
   parameter int unsigned HIGH_CYC = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   input  acc_e kind,
   output logic cs_n,
   output logic rd_n,
   output logic wr_n,
   output logic ss_n,
   output logic sample,
   output logic ack
);
   localparam int unsigned TOT = LOW_CYC + HIGH_CYC;
   localparam int unsigned CW  = $clog2(TOT + 1);

   logic          active;
   logic [CW-1:0] cnt;
   acc_e          kind_q;
   logic          low;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cnt    <= '0;
         kind_q <= ACC_STATUS;
      end else if (!active) begin
         cnt <= '0;
         if (req) begin
            active <= 1'b1;
            kind_q <= kind;
         end
      end else if (cnt == CW'(TOT - 1)) begin
         active <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign low    = active && (cnt < CW'(LOW_CYC));
   assign cs_n   = !low;
   assign ss_n   = !(low && kind_q == ACC_STATUS);
   assign wr_n   = !(low && kind_q == ACC_START);
   assign rd_n   = !(low && kind_q == ACC_DATA);
   assign sample = active && (cnt == CW'(LOW_CYC - 1));
   assign ack    = active && (cnt == CW'(TOT - 1));

endmodule

// File: rtl/adcseq_retry.sv
module adcseq_retry #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (inc && !last)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/adcseq_stab.sv
module adcseq_stab #(
   parameter int unsigned HI_BITS = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic               load,
   input  logic [HI_BITS-1:0] hi,
   input  logic [7:0]         lo,
   output logic [15:0]        reading,
   output logic               match
);
   logic [15:0] prev_q;

   assign reading = {(16 - HI_BITS - 8)'(0), hi, lo};
   assign match   = (reading == prev_q);

   always_ff @(posedge clk) begin
      if (rst || clr)
         prev_q <= '0;
      else if (load)
         prev_q <= reading;
   end

endmodule

// File: rtl/adc_handshake_seq.sv
module adc_handshake_seq
   import adcseq_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 12,
   parameter int unsigned LOW_CYC     = 4,
   parameter int unsigned HIGH_CYC    = 4,
   parameter int unsigned START_DLY   = 8,
   parameter int unsigned SETTLE_CYC  = 9000,
   parameter int unsigned BUSY_TRIES  = 50,
   parameter int unsigned READY_TRIES = 20,
   parameter int unsigned READ_TRIES  = 10
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        start,
   input  logic [7:0]  bus_in,
   output logic        cs_n,
   output logic        rd_n,
   output logic        wr_n,
   output logic        ss_n,
   output logic        busy,
   output logic        done,
   output logic [15:0] result,
   output logic        error
);
   localparam int unsigned RES_BITS = DATA_BITS + 1;
   localparam int unsigned HI_BITS  = RES_BITS - 8;

   if (LOW_CYC < 1) begin : g_bad_low
      $error("LOW_CYC must be at least 1");
   end
   if (HIGH_CYC < 1) begin : g_bad_high
      $error("HIGH_CYC must be at least 1");
   end
   if (DATA_BITS < 8 || DATA_BITS > 14) begin : g_bad_bits
      $error("DATA_BITS must lie in 8..14");
   end
   if (START_DLY < 1 || SETTLE_CYC < 1 || BUSY_TRIES < 1 ||
       READY_TRIES < 1 || READ_TRIES < 1) begin : g_bad_count
      $error("all counts must be at least 1");
   end

   function automatic int unsigned limit_of(input int idx);
      case (idx)
         CNT_BUSY:   return BUSY_TRIES;
         CNT_DLY:    return START_DLY;
         CNT_SETTLE: return SETTLE_CYC;
         CNT_READY:  return READY_TRIES;
         default:    return READ_TRIES;
      endcase
   endfunction

   state_e             state;
   logic               req;
   acc_e               kind;
   logic               sample;
   logic               ack;
   logic [7:0]         cap_q;
   logic [HI_BITS-1:0] hi_q;
   logic [NCNT-1:0]    inc;
   logic [NCNT-1:0]    last;
   logic               cnt_clr;
   logic [15:0]        reading;
   logic               match;
   logic               stab_load;

   adcseq_strobe #(
      .LOW_CYC (LOW_CYC),
      .HIGH_CYC(HIGH_CYC)
   ) u_strobe (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .kind  (kind),
      .cs_n  (cs_n),
      .rd_n  (rd_n),
      .wr_n  (wr_n),
      .ss_n  (ss_n),
      .sample(sample),
      .ack   (ack)
   );

   assign cnt_clr = (state == ST_IDLE);

   for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      adcseq_retry #(
         .LIMIT(limit_of(g))
      ) u_retry (
         .clk (clk),
         .rst (rst),
         .clr (cnt_clr),
         .inc (inc[g]),
         .last(last[g])
      );
   end

   assign stab_load = (state == ST_RDLO) && ack;

   adcseq_stab #(
      .HI_BITS(HI_BITS)
   ) u_stab (
      .clk    (clk),
      .rst    (rst),
      .clr    (cnt_clr),
      .load   (stab_load),
      .hi     (hi_q),
      .lo     (cap_q),
      .reading(reading),
      .match  (match)
   );

   always_comb begin
      req  = 1'b0;
      kind = ACC_STATUS;
      inc  = '0;
      case (state)
         ST_BUSYCHK: begin
            req = 1'b1;
            inc[CNT_BUSY] = ack && cap_q[BIT_INPROG];
         end
         ST_CONFIRM: req = 1'b1;
         ST_POLL: begin
            req = 1'b1;
            inc[CNT_READY] = ack && !cap_q[BIT_READY];
         end
         ST_START: begin
            req  = 1'b1;
            kind = ACC_START;
         end
         ST_ALIGN, ST_RDHI: begin
            req  = 1'b1;
            kind = ACC_DATA;
         end
         ST_RDLO: begin
            req  = 1'b1;
            kind = ACC_DATA;
            inc[CNT_READ] = ack && !match;
         end
         ST_DELAY:  inc[CNT_DLY]    = 1'b1;
         ST_SETTLE: inc[CNT_SETTLE] = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         done   <= 1'b0;
         result <= '0;
         error  <= 1'b0;
         cap_q  <= '0;
         hi_q   <= '0;
      end else begin
         done <= 1'b0;
         if (sample)
            cap_q <= bus_in;
         case (state)
            ST_IDLE:
               if (start)
                  state <= ST_BUSYCHK;
            ST_BUSYCHK:
               if (ack) begin
                  if (!cap_q[BIT_INPROG]) begin
                     state <= ST_START;
                  end else if (last[CNT_BUSY]) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= CODE_BUSY;
                     error  <= 1'b1;
                  end
               end
            ST_START:
               if (ack)
                  state <= ST_DELAY;
            ST_DELAY:
               if (last[CNT_DLY])
                  state <= ST_CONFIRM;
            ST_CONFIRM:
               if (ack) begin
                  if (cap_q[BIT_INPROG]) begin
                     state <= ST_SETTLE;
                  end else begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= CODE_NOSTART;
                     error  <= 1'b1;
                  end
               end
            ST_SETTLE:
               if (last[CNT_SETTLE])
                  state <= ST_POLL;
            ST_POLL:
               if (ack) begin
                  if (cap_q[BIT_READY]) begin
                     state <= cap_q[BIT_LATCH] ? ST_ALIGN : ST_RDHI;
                  end else if (last[CNT_READY]) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= CODE_STUCK;
                     error  <= 1'b1;
                  end
               end
            ST_ALIGN:
               if (ack)
                  state <= ST_RDHI;
            ST_RDHI:
               if (ack) begin
                  hi_q  <= cap_q[HI_BITS-1:0];
                  state <= ST_RDLO;
               end
            ST_RDLO:
               if (ack) begin
                  if (match) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= reading;
                     error  <= 1'b0;
                  end else if (last[CNT_READ]) begin
                     state  <= ST_IDLE;
                     done   <= 1'b1;
                     result <= CODE_UNSTABLE;
                     error  <= 1'b0;
                  end else begin
                     state <= ST_RDHI;
                  end
               end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/adcseq_checks.sv
module adcseq_checks #(
   parameter int unsigned LOW_CYC = 4
) (
   input logic        clk,
   input logic        rst,
   input logic        start,
   input logic        cs_n,
   input logic        rd_n,
   input logic        wr_n,
   input logic        ss_n,
   input logic        busy,
   input logic        done,
   input logic [15:0] result,
   input logic        error
);
   logic [15:0] lowcnt;

   always_ff @(posedge clk) begin
      if (rst)
         lowcnt <= '0;
      else if (!cs_n)
         lowcnt <= lowcnt + 16'd1;
      else
         lowcnt <= '0;
   end

   // R1: bus idle whenever no run is active
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (cs_n && rd_n && wr_n && ss_n));

   // R2: each function strobe only together with chip select, one at a time
   assert_strobe_pair_R2: assert property (@(posedge clk) disable iff (rst)
      !cs_n |-> ($countones({rd_n, wr_n, ss_n}) == 2));
   assert_strobe_cs_R2: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !wr_n || !ss_n) |-> !cs_n);
   assert_low_width_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (lowcnt == 16'(LOW_CYC)));

   // R9: done pulse framing and result holding
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);
   assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !$stable(result) |-> done);
   assert_error_code_R9: assert property (@(posedge clk) disable iff (rst)
      (done && error) |-> (result >= 16'hFFFD));

   // R10: a start while idle always launches a run
   assert_start_launch_R10: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

endmodule

bind adc_handshake_seq adcseq_checks #(
   .LOW_CYC(LOW_CYC)
) u_checks (
   .clk   (clk),
   .rst   (rst),
   .start (start),
   .cs_n  (cs_n),
   .rd_n  (rd_n),
   .wr_n  (wr_n),
   .ss_n  (ss_n),
   .busy  (busy),
   .done  (done),
   .result(result),
   .error (error)
);

// File: tb/adc_handshake_seq_bench.sv
module adc_handshake_seq_bench;
   localparam int L   = 2;
   localparam int H   = 1;
   localparam int D   = 2;
   localparam int S   = 5;
   localparam int BT  = 4;
   localparam int RT  = 3;
   localparam int RDT = 4;
   localparam int A   = L + H + 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [7:0]  bus_in;
   logic        cs_n, rd_n, wr_n, ss_n, busy, done, error;
   logic [15:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   // converter model state and scenario knobs
   int m_k, m_sok, m_p, m_nz;
   logic [12:0] m_val;
   int pre_n, post_n, hcnt;
   bit started, ptr;
   bit p_ss, p_wr, p_rd, p_cs;
   int lowrun, bad_w, bad_c;

   always #5 clk = ~clk;

   adc_handshake_seq #(
      .DATA_BITS(12), .LOW_CYC(L), .HIGH_CYC(H), .START_DLY(D),
      .SETTLE_CYC(S), .BUSY_TRIES(BT), .READY_TRIES(RT), .READ_TRIES(RDT)
   ) u_adc_handshake_seq (
      .clk(clk), .rst(rst), .start(start), .bus_in(bus_in),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ss_n(ss_n),
      .busy(busy), .done(done), .result(result), .error(error)
   );

   function automatic logic [12:0] fval(input int j);
      if (j < m_nz) return m_val ^ 13'((j + 1) << 4);
      return m_val;
   endfunction

   always @* begin
      logic rdy;
      logic [7:0] b;
      b = 8'h00;
      if (!ss_n) begin
         if (!started) begin
            b[6] = (pre_n < m_k);
         end else if (post_n == 0) begin
            b[6] = (m_sok != 0);
         end else begin
            rdy  = ((post_n - 1) >= m_p);
            b[6] = !rdy;
            b[1] = rdy;
            b[0] = rdy;
         end
         b[2] = ptr;
      end else if (!rd_n) begin
         if (!ptr) b = {3'b111, fval(hcnt)[12:8]};
         else if (hcnt == 0) b = 8'hAA;
         else b = fval(hcnt - 1)[7:0];
      end
      bus_in = b;
   end

   always @(negedge clk) begin
      cycles++;
      if (!p_ss && ss_n) begin
         if (!started) pre_n++;
         else post_n++;
      end
      if (!p_wr && wr_n) started = 1'b1;
      if (!p_rd && rd_n) begin
         if (!ptr) hcnt++;
         ptr = !ptr;
      end
      if (!cs_n) begin
         lowrun++;
         if ((int'(rd_n) + int'(wr_n) + int'(ss_n)) != 2) bad_c++;
      end else begin
         if (!p_cs && lowrun != L) bad_w++;
         lowrun = 0;
      end
      p_ss = ss_n; p_wr = wr_n; p_rd = rd_n; p_cs = cs_n;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin : watchdog
      wait (cycles > 190000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      report();
   end

   task automatic run_case(input int k, input int sok, input int p,
                           input int lf, input int nz, input logic [12:0] val);
      int tot, need, n, exp_cyc;
      logic [15:0] exp_res;
      bit exp_err;
      m_k = k; m_sok = sok; m_p = p; m_nz = nz; m_val = val;
      pre_n = 0; post_n = 0; hcnt = 0; started = 0; ptr = bit'(lf);
      // expected outcome and latency
      if (k >= BT) begin
         exp_res = 16'hFFFF; exp_err = 1; tot = BT * A;
      end else begin
         tot = (k + 1) * A + A + D + A;
         if (sok == 0) begin
            exp_res = 16'hFFFE; exp_err = 1;
         end else begin
            tot += S;
            if (p >= RT) begin
               exp_res = 16'hFFFD; exp_err = 1; tot += RT * A;
            end else begin
               tot += (p + 1) * A + (lf != 0 ? A : 0);
               need = (nz == 0 && val == 0) ? 1 : nz + 2;
               exp_err = 0;
               if (need > RDT) begin
                  exp_res = 16'h0000; tot += RDT * 2 * A;
               end else begin
                  exp_res = {3'b000, val}; tot += need * 2 * A;
               end
            end
         end
      end
      exp_cyc = 1 + tot;
      start = 1'b1;
      @(posedge clk);
      n = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         start = (n == 3); // stray start while busy (R10)
      end
      start = 1'b0;
      check(n == exp_cyc, "R11", "done latency", n, exp_cyc);
      if (exp_err && exp_res == 16'hFFFF)
         check(result == exp_res, "R3", "busy code", result, exp_res);
      else if (exp_err && exp_res == 16'hFFFE)
         check(result == exp_res, "R4", "no-start code", result, exp_res);
      else if (exp_err)
         check(result == exp_res, "R5", "stuck code", result, exp_res);
      else if (lf != 0)
         check(result == exp_res, "R6", "aligned result", result, exp_res);
      else if (exp_res == 16'h0000 && val != 0)
         check(result == exp_res, "R8", "unstable result", result, exp_res);
      else
         check(result == exp_res, "R7", "assembled result", result, exp_res);
      check(error == exp_err, "R9", "error flag", error, exp_err);
      repeat (4) @(negedge clk);
      check(!busy && cs_n && !done, "R10", "idle after run", {busy, cs_n, done}, 3'b010);
   endtask

   initial begin : stim
      logic [12:0] vals [4];
      vals[0] = 13'h0000; vals[1] = 13'h1A5C; vals[2] = 13'h00F3; vals[3] = 13'h1001;
      p_ss = 1; p_wr = 1; p_rd = 1; p_cs = 1; lowrun = 0; bad_w = 0; bad_c = 0;
      m_k = 0; m_sok = 1; m_p = 0; m_nz = 0; m_val = '0;
      pre_n = 0; post_n = 0; hcnt = 0; started = 0; ptr = 0;
      repeat (3) @(negedge clk);
      check(cs_n && rd_n && wr_n && ss_n, "R1", "strobes in reset",
            {cs_n, rd_n, wr_n, ss_n}, 4'hF);
      rst = 1'b0;
      @(negedge clk);
      check(!busy && !done && result == 16'h0000, "R1", "idle after reset",
            {busy, done, result}, 0);
      for (int k = 0; k <= BT; k++)
         for (int sok = 0; sok <= 1; sok++)
            for (int p = 0; p <= RT; p++)
               for (int lf = 0; lf <= 1; lf++)
                  for (int nz = 0; nz <= RDT; nz++)
                     run_case(k, sok, p, lf, nz, vals[(k + p + nz) % 4]);
      // first reading of zero is accepted against the zero seed (R8)
      run_case(0, 1, 0, 0, 0, 13'h0000);
      check(result == 16'h0000 && !error, "R8", "zero seed accept", result, 0);
      check(bad_w == 0, "R2", "strobe low width errors", bad_w, 0);
      check(bad_c == 0, "R2", "strobe combination errors", bad_c, 0);
      report();
   end

endmodule